// File: doc/BRIEF.md
# Overlapped windowed register file

This block is the integer register file of a 32-bit RISC pipeline. The program always sees 32 logical registers. They are eight globals plus a 24-register window made of out, local and in groups. A 2-bit current-window pointer selects the window. Neighbouring windows share storage: the out group of a caller is the same physical storage as the in group of the procedure it calls. Arguments therefore pass across a call without any copying.

A save-type operation moves the pointer down by one window and a restore-type operation moves it up by one, both modulo the number of windows. A mask of invalid windows, supplied by the surrounding trap logic, blocks any move onto a marked window. A blocked save raises an overflow pulse and a blocked restore raises an underflow pulse; in both cases the pointer does not move. The block has two read ports and one write port. The read ports are combinational and return the new value when they read the register being written in the same cycle.

Top module: `regwin_file`

## Requirements
- R1: Logical register numbers decode on bits [4:3]: 0 selects globals (r0–r7), 1 outs (r8–r15), 2 locals (r16–r23), 3 ins (r24–r31). Each window's locals are private to that window.
- R2: r0 always reads as zero, and writes to it have no effect.
- R3: Globals r1–r7 are the same storage in every window.
- R4: The outs of window w are the ins of window w−1 (mod 4), so a value written to r8 before a save is read back as r24 after it, and the reverse holds across a restore.
- R5: After reset the pointer is 0 and every register reads zero. A save sets the pointer to cwp−1 and a restore sets it to cwp+1, both modulo 4, so 0 goes to 3 on a save and 3 goes to 0 on a restore. The new value shows on cwp_o after the clock edge.
- R6: A save whose target window has its bit set in wim_i (bit index = target window number) leaves the pointer unchanged and drives ovf_o high for exactly the one cycle after that edge.
- R7: A restore whose target window is marked in wim_i leaves the pointer unchanged and drives unf_o high for exactly the one cycle after that edge.
- R8: When save_i and restore_i are high together, only the save acts; the restore is ignored and raises no underflow.
- R9: A read of the register being written in the same cycle returns wr_data_i (write-first).
- R10: A write in the same cycle as a save or restore goes to the window the pointer selected before the move.
- R11: The two read ports are independent, and each can return a different register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_addr_i | input | 5 | Read port A logical register |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 5 | Read port B logical register |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write logical register |
| wr_data_i | input | 32 | Write data |
| save_i | input | 1 | Move the pointer down one window |
| restore_i | input | 1 | Move the pointer up one window |
| wim_i | input | 4 | Invalid-window mask, one bit per window |
| cwp_o | output | 2 | Current-window pointer |
| ovf_o | output | 1 | Blocked save, one-cycle pulse |
| unf_o | output | 1 | Blocked restore, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: four windows of 32-bit registers, which gives 72 physical entries. At that size every pointer value and both wrap points (0 on a save, 3 on a restore) are reached within a few operations. The mask can mark each neighbour of window 0 in turn, so both the blocked save and the blocked restore are tested. Sharing through the ring is checked from both sides of window 0, including the pair that closes the ring across the wrap.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned LREG_W = 5;
  localparam int unsigned GRP_N  = 8;
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN   = 4,
  parameter int unsigned CWP_W  = 2,
  parameter int unsigned PIDX_W = 7
) (
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [LREG_W-1:0] laddr_i,
  output logic [PIDX_W-1:0] pidx_o
);
  localparam int unsigned PHYS = GRP_N + NWIN * 2 * GRP_N;

  reg_grp_e grp;
  int unsigned off, win, up;

  always_comb begin
    grp = reg_grp_e'(laddr_i[LREG_W-1:LREG_W-2]);
    off = int'(laddr_i[LREG_W-3:0]);
    win = int'(cwp_i);
    up  = (win == NWIN - 1) ? 0 : win + 1;  // ins live in the caller's out bank
    unique case (grp)
      GRP_GLOBAL: pidx_o = PIDX_W'(off);
      GRP_OUT:    pidx_o = PIDX_W'(GRP_N + win * 2 * GRP_N + off);
      GRP_LOCAL:  pidx_o = PIDX_W'(GRP_N + win * 2 * GRP_N + GRP_N + off);
      default:    pidx_o = PIDX_W'(GRP_N + up * 2 * GRP_N + off);
    endcase
  end

  always_comb begin
    a_r1_phys_in_range: assert (int'(pidx_o) < PHYS || $isunknown(laddr_i));
  end
endmodule

// File: rtl/regwin_cwp.sv
module regwin_cwp #(
  parameter int unsigned NWIN  = 4,
  parameter int unsigned CWP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CWP_W-1:0] cwp_q, cwp_dn, cwp_up;
  logic             save_ok, save_bad, rest_ok, rest_bad, rest_req;

  always_comb begin
    cwp_dn   = (cwp_q == '0) ? CWP_W'(NWIN - 1) : cwp_q - 1'b1;
    cwp_up   = (int'(cwp_q) == NWIN - 1) ? '0 : cwp_q + 1'b1;
    rest_req = restore_i && !save_i;  // save has priority
    save_bad = save_i && wim_i[cwp_dn];
    save_ok  = save_i && !wim_i[cwp_dn];
    rest_bad = rest_req && wim_i[cwp_up];
    rest_ok  = rest_req && !wim_i[cwp_up];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (save_ok)      cwp_q <= cwp_dn;
      else if (rest_ok) cwp_q <= cwp_up;
      ovf_o <= save_bad;
      unf_o <= rest_bad;
    end
  end

  assign cwp_o = cwp_q;

  a_r5_save_moves_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !wim_i[cwp_dn]) |=>
      ((int'(cwp_o) + 1 == int'($past(cwp_o))) ||
       ($past(cwp_o) == '0 && int'(cwp_o) == NWIN - 1)));
  a_r5_restore_moves_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !wim_i[cwp_up]) |=>
      ((int'(cwp_o) == int'($past(cwp_o)) + 1) ||
       (int'($past(cwp_o)) == NWIN - 1 && cwp_o == '0)));
  a_r6_overflow_holds_cwp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && wim_i[cwp_dn]) |=> (ovf_o && $stable(cwp_o)));
  a_r7_underflow_holds_cwp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && wim_i[cwp_up]) |=> (unf_o && $stable(cwp_o)));
  a_r8_save_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> !unf_o);
  a_r6_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PHYS   = 72,
  parameter int unsigned PIDX_W = 7,
  parameter int unsigned NRD    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [PIDX_W-1:0]            widx_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [NRD-1:0][PIDX_W-1:0]   ridx_i,
  output logic [NRD-1:0][DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] mem_q [PHYS];
  logic              wr_live;

  assign wr_live = we_i && (widx_i != '0);  // entry 0 is the hard zero

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
    end else if (wr_live) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (ridx_i[p] == '0)                   rdata_o[p] = '0;
      else if (wr_live && widx_i == ridx_i[p]) rdata_o[p] = wdata_i;
      else                                   rdata_o[p] = mem_q[ridx_i[p]];
    end
  end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWIN   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [4:0]               ra_addr_i,
  output logic [DATA_W-1:0]        ra_data_o,
  input  logic [4:0]               rb_addr_i,
  output logic [DATA_W-1:0]        rb_data_o,
  input  logic                     we_i,
  input  logic [4:0]               wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic [NWIN-1:0]          wim_i,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  localparam int unsigned CWP_W  = $clog2(NWIN);
  localparam int unsigned PHYS   = GRP_N + NWIN * 2 * GRP_N;
  localparam int unsigned PIDX_W = $clog2(PHYS);
  localparam int unsigned NRD    = 2;
  localparam int unsigned NPORT  = NRD + 1;

  logic [NPORT-1:0][LREG_W-1:0] laddr;
  logic [NPORT-1:0][PIDX_W-1:0] pidx;
  logic [NRD-1:0][DATA_W-1:0]   rdata;
  logic [CWP_W-1:0]             cwp;

  assign laddr = {wr_addr_i, rb_addr_i, ra_addr_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    regwin_xlate #(.NWIN(NWIN), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) u_xlate (
      .cwp_i   (cwp),
      .laddr_i (laddr[p]),
      .pidx_o  (pidx[p])
    );
  end

  regwin_cwp #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .save_i    (save_i),
    .restore_i (restore_i),
    .wim_i     (wim_i),
    .cwp_o     (cwp),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  regwin_store #(.DATA_W(DATA_W), .PHYS(PHYS), .PIDX_W(PIDX_W), .NRD(NRD)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .widx_i  (pidx[NRD]),
    .wdata_i (wr_data_i),
    .ridx_i  (pidx[NRD-1:0]),
    .rdata_o (rdata)
  );

  assign ra_data_o = rdata[0];
  assign rb_data_o = rdata[1];
  assign cwp_o     = cwp;

  a_r2_r0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == '0) |-> (ra_data_o == '0));
  a_r9_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_addr_i == ra_addr_i && wr_addr_i != '0) |-> (ra_data_o == wr_data_i));
  a_r10_write_lands_old_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_addr_i != '0 && wr_addr_i == ra_addr_i && !save_i && !restore_i)
      |=> (ra_addr_i != $past(ra_addr_i) || we_i || ra_data_o == $past(wr_data_i)));
endmodule

// File: tb/regwin_file_tb.sv
module regwin_file_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic [31:0] ra_data, rb_data, wr_data = '0;
  logic        we = 1'b0, save = 1'b0, restore = 1'b0;
  logic [3:0]  wim = '0;
  logic [1:0]  cwp;
  logic        ovf, unf;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_file u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ra_addr_i(ra_addr), .ra_data_o(ra_data),
    .rb_addr_i(rb_addr), .rb_data_o(rb_data),
    .we_i(we), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .save_i(save), .restore_i(restore), .wim_i(wim),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    ra_addr = a;
    #1 d = ra_data;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; wr_addr = a; wr_data = d;
    step();
    we = 1'b0;
  endtask

  task automatic do_save();
    save = 1'b1; step(); save = 1'b0;
  endtask

  task automatic do_restore();
    restore = 1'b1; step(); restore = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R5 reset cwp", 32'(cwp), 0);
    chk("R6 reset ovf", 32'(ovf), 0);
    chk("R7 reset unf", 32'(unf), 0);
    rd(5'd16, d); chk("R5 reset contents r16", d, 0);
    rd(5'd5, d);  chk("R5 reset contents r5", d, 0);
  endtask

  task automatic t_r0();
    logic [31:0] d;
    ra_addr = 5'd0; we = 1'b1; wr_addr = 5'd0; wr_data = 32'hDEAD_BEEF;
    #1 chk("R2 r0 same-cycle read", ra_data, 0);
    step(); we = 1'b0;
    rd(5'd0, d); chk("R2 r0 after write", d, 0);
  endtask

  task automatic t_globals();
    logic [31:0] d;
    wr(5'd1, 32'h1111_0001);
    do_save();
    chk("R5 save 0->3 wrap", 32'(cwp), 3);
    rd(5'd1, d); chk("R3 global in window 3", d, 32'h1111_0001);
    do_restore();
    chk("R5 restore 3->0 wrap", 32'(cwp), 0);
  endtask

  task automatic t_overlap();
    logic [31:0] d;
    wr(5'd8, 32'hA0A0_0008);
    do_save();
    rd(5'd24, d); chk("R4 caller out r8 is callee in r24", d, 32'hA0A0_0008);
    wr(5'd24, 32'hB0B0_0018);
    do_restore();
    rd(5'd8, d); chk("R4 callee in write seen as caller out", d, 32'hB0B0_0018);
    wr(5'd24, 32'hC0C0_0018);
    do_restore();
    chk("R5 restore 0->1", 32'(cwp), 1);
    rd(5'd8, d); chk("R4 window1 out is window0 in", d, 32'hC0C0_0018);
    rd(5'd16, d); chk("R1 window1 local untouched", d, 0);
    do_save();
    chk("R5 save 1->0", 32'(cwp), 0);
  endtask

  task automatic t_locals();
    logic [31:0] d;
    wr(5'd16, 32'h10CA_0000);
    do_save();
    rd(5'd16, d); chk("R1 local private in window 3", d, 0);
    wr(5'd16, 32'h10CA_0003);
    do_restore();
    rd(5'd16, d); chk("R1 window0 local kept", d, 32'h10CA_0000);
  endtask

  task automatic t_wrap();
    for (int k = 1; k <= 4; k++) begin
      do_restore();
      chk("R5 restore walk", 32'(cwp), 32'(k % 4));
    end
  endtask

  task automatic t_overflow();
    wim = 4'b1000;
    do_save();
    chk("R6 ovf pulse", 32'(ovf), 1);
    chk("R6 cwp held", 32'(cwp), 0);
    chk("R6 no unf", 32'(unf), 0);
    step();
    chk("R6 ovf one cycle", 32'(ovf), 0);
    wim = 4'b0000;
  endtask

  task automatic t_underflow();
    wim = 4'b0010;
    do_restore();
    chk("R7 unf pulse", 32'(unf), 1);
    chk("R7 cwp held", 32'(cwp), 0);
    chk("R7 no ovf", 32'(ovf), 0);
    step();
    chk("R7 unf one cycle", 32'(unf), 0);
    wim = 4'b0000;
  endtask

  task automatic t_both();
    wim = 4'b0010;  // restore target masked: an acting restore would pulse unf
    save = 1'b1; restore = 1'b1; step(); save = 1'b0; restore = 1'b0;
    chk("R8 save wins cwp", 32'(cwp), 3);
    chk("R8 no unf", 32'(unf), 0);
    wim = 4'b0000;
    do_restore();
    chk("R8 back to 0", 32'(cwp), 0);
  endtask

  task automatic t_bypass();
    ra_addr = 5'd20; rb_addr = 5'd20;
    we = 1'b1; wr_addr = 5'd20; wr_data = 32'h5A5A_0014;
    #1 chk("R9 port A write-first", ra_data, 32'h5A5A_0014);
    chk("R9 port B write-first", rb_data, 32'h5A5A_0014);
    step(); we = 1'b0;
    #1 chk("R9 value kept", ra_data, 32'h5A5A_0014);
  endtask

  task automatic t_write_with_save();
    logic [31:0] d;
    we = 1'b1; wr_addr = 5'd17; wr_data = 32'h0BAD_0011; save = 1'b1;
    step(); we = 1'b0; save = 1'b0;
    rd(5'd17, d); chk("R10 not in new window", d, 0);
    do_restore();
    rd(5'd17, d); chk("R10 landed in old window", d, 32'h0BAD_0011);
  endtask

  task automatic t_dual();
    ra_addr = 5'd1; rb_addr = 5'd16;
    #1 chk("R11 port A", ra_data, 32'h1111_0001);
    chk("R11 port B", rb_data, 32'h10CA_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_r0();
    t_globals();
    t_overlap();
    t_locals();
    t_wrap();
    t_overflow();
    t_underflow();
    t_both();
    t_bypass();
    t_write_with_save();
    t_dual();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule